// File: doc/BRIEF.md
# Banked Input Matrix Scanner

The scanner reads a grid of digital inputs through one shared 8-bit input port. Each row of the grid is wired behind its own select line. While the block is enabled, it raises one select line at a time. It holds that line for a settling dwell, then captures the eight shared inputs into the result array at that row's position. After that it moves to the next row. When the last configured row is captured, the scan wraps back to row 0 and keeps cycling for as long as the enable stays high.

The dwell is counted in pulses of an external tick, which is nominally 1 ms. Normal mode uses a long dwell that matches a slow input filter. Fast mode halves it. A flag reports that the whole grid has been read at least once since the scan was last started. Dropping the enable stops the scan, turns off every select line and clears the flag. The captured values are kept.

Top module: `bank_matrix_scan`

## Requirements
- R1: While the scan runs, exactly one bit of `row_sel` is high. Bit 0 goes high on the first clock edge after `scan_en` is sampled high while the block is idle.
- R2: While `scan_en` is low, all of `row_sel` is low from the next edge on. Reasserting `scan_en` always restarts at row 0.
- R3: Each row is held for `NORM_TICKS` tick pulses (for `fast_mode`=0) or `FAST_TICKS` pulses (for `fast_mode`=1). Clock cycles with `tick` low do not advance the scan.
- R4: On the edge carrying the last tick of a row's dwell, `in_bits` is stored in `matrix[8*b+7 : 8*b]` for row b, with in_bits[i] going to matrix[8*b+i].
- R5: `row_count` and `fast_mode` are latched when the scan starts. A row count below 2 is treated as 2, and a count above `MAX_BANKS` is treated as `MAX_BANKS`.
- R6: `scan_done` rises on the edge that captures the last configured row of the first pass. That edge comes 1 + rows·dwell ticked edges after start. The flag then stays high over later passes.
- R7: `scan_done` is low on the edge after `scan_en` is sampled low.
- R8: `matrix` does not change while the scan is disabled. Rows at or above the latched row count are never written. Every configured row is rewritten on every pass.
- R9: Synchronous reset clears `row_sel`, `scan_done` and all of `matrix`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_en | input | 1 | Runs the scan while held high |
| tick | input | 1 | One-cycle timebase pulse (nominally 1 ms) |
| fast_mode | input | 1 | Selects the short dwell when high |
| row_count | input | $clog2(MAX_BANKS+1) | Requested number of rows |
| in_bits | input | LANES | Shared input lines |
| row_sel | output | MAX_BANKS | One-hot row select |
| matrix | output | MAX_BANKS*LANES | Captured grid, row b in bits 8b+7..8b |
| scan_done | output | 1 | First full pass complete |

## Verification
The bench builds the block with `MAX_BANKS`=8, `NORM_TICKS`=4 and `FAST_TICKS`=2. This keeps the dwell ratio of the real settings while letting a full eight-row pass finish in a few dozen cycles. With these values, passes at 2, 3, 5 and 8 rows fit in the run, in both dwell modes. So do requests of 0 and 15, which exercise the clamp at both ends. The exact done cycle can then be predicted from the row count and the dwell. The short dwell also leaves room for a second pass, a mid-scan disable and a long stall on the tick.

// File: rtl/bms_pkg.sv
package bms_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } scan_phase_e;

    // Limit a requested row count to the legal window.
    function automatic int clamp_rows(input int req, input int lo, input int hi);
        if (req < lo)      return lo;
        else if (req > hi) return hi;
        else               return req;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/bms_dwell_timer.sv
module bms_dwell_timer
    import bms_pkg::*;
#(
    parameter int NORM_TICKS = 20,
    parameter int FAST_TICKS = 10,
    localparam int CW = $clog2(max2(NORM_TICKS, FAST_TICKS) + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic running,
    input  logic fast,
    input  logic tick,
    output logic expire
);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last_val;

    assign last_val = fast ? CW'(FAST_TICKS - 1) : CW'(NORM_TICKS - 1);
    assign expire   = running && tick && (cnt_q == last_val);

    always_ff @(posedge clk) begin
        if (rst || !running) begin
            cnt_q <= '0;
        end else if (tick) begin
            if (expire) cnt_q <= '0;
            else        cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/bms_bank_seq.sv
module bms_bank_seq
    import bms_pkg::*;
#(
    parameter int MAX_BANKS = 8,
    parameter int MIN_BANKS = 2,
    localparam int REQ_W = $clog2(MAX_BANKS + 1),
    localparam int IDX_W = (MAX_BANKS > 1) ? $clog2(MAX_BANKS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 enable,
    input  logic [REQ_W-1:0]     req_rows,
    input  logic                 req_fast,
    input  logic                 step,
    output logic                 running,
    output logic                 fast_q,
    output logic [IDX_W-1:0]     bank_idx,
    output logic [MAX_BANKS-1:0] sel,
    output logic                 wr_en,
    output logic                 done
);

    scan_phase_e      phase_q;
    logic [IDX_W-1:0] bank_q;
    logic [IDX_W-1:0] top_q;
    logic             done_q;
    logic             fast_r;
    logic             at_top;

    assign running  = (phase_q == PH_RUN);
    assign at_top   = (bank_q == top_q);
    assign wr_en    = running && enable && step;
    assign bank_idx = bank_q;
    assign fast_q   = fast_r;
    assign done     = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            bank_q  <= '0;
            top_q   <= '0;
            done_q  <= 1'b0;
            fast_r  <= 1'b0;
        end else if (!enable) begin
            phase_q <= PH_IDLE;
            bank_q  <= '0;
            done_q  <= 1'b0;
        end else if (phase_q == PH_IDLE) begin
            phase_q <= PH_RUN;
            bank_q  <= '0;
            top_q   <= IDX_W'(clamp_rows(int'(req_rows), MIN_BANKS, MAX_BANKS) - 1);
            fast_r  <= req_fast;
        end else if (step) begin
            if (at_top) begin
                bank_q <= '0;
                done_q <= 1'b1;
            end else begin
                bank_q <= bank_q + 1'b1;
            end
        end
    end

    for (genvar g = 0; g < MAX_BANKS; g++) begin : g_sel
        assign sel[g] = running && (bank_q == IDX_W'(g));
    end

endmodule

// File: rtl/bms_row_store.sv
module bms_row_store #(
    parameter int LANES     = 8,
    parameter int MAX_BANKS = 8,
    localparam int IDX_W = (MAX_BANKS > 1) ? $clog2(MAX_BANKS) : 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr,
    input  logic [IDX_W-1:0]           wr_row,
    input  logic [LANES-1:0]           wr_data,
    output logic [MAX_BANKS*LANES-1:0] rows
);

    for (genvar r = 0; r < MAX_BANKS; r++) begin : g_row
        logic [LANES-1:0] row_q;
        always_ff @(posedge clk) begin
            if (rst)                                row_q <= '0;
            else if (wr && (wr_row == IDX_W'(r)))   row_q <= wr_data;
        end
        assign rows[r*LANES +: LANES] = row_q;
    end

endmodule

// File: rtl/bank_matrix_scan.sv
module bank_matrix_scan
    import bms_pkg::*;
#(
    parameter int LANES      = 8,
    parameter int MAX_BANKS  = 8,
    parameter int NORM_TICKS = 20,
    parameter int FAST_TICKS = 10,
    localparam int REQ_W = $clog2(MAX_BANKS + 1),
    localparam int IDX_W = (MAX_BANKS > 1) ? $clog2(MAX_BANKS) : 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       scan_en,
    input  logic                       tick,
    input  logic                       fast_mode,
    input  logic [REQ_W-1:0]           row_count,
    input  logic [LANES-1:0]           in_bits,
    output logic [MAX_BANKS-1:0]       row_sel,
    output logic [MAX_BANKS*LANES-1:0] matrix,
    output logic                       scan_done
);

    logic             scan_run;
    logic             fast_lat;
    logic             dwell_end;
    logic             cap_wr;
    logic [IDX_W-1:0] cur_row;

    bms_dwell_timer #(
        .NORM_TICKS (NORM_TICKS),
        .FAST_TICKS (FAST_TICKS)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .running (scan_run),
        .fast    (fast_lat),
        .tick    (tick),
        .expire  (dwell_end)
    );

    bms_bank_seq #(
        .MAX_BANKS (MAX_BANKS),
        .MIN_BANKS (2)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .enable   (scan_en),
        .req_rows (row_count),
        .req_fast (fast_mode),
        .step     (dwell_end),
        .running  (scan_run),
        .fast_q   (fast_lat),
        .bank_idx (cur_row),
        .sel      (row_sel),
        .wr_en    (cap_wr),
        .done     (scan_done)
    );

    bms_row_store #(
        .LANES     (LANES),
        .MAX_BANKS (MAX_BANKS)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr      (cap_wr),
        .wr_row  (cur_row),
        .wr_data (in_bits),
        .rows    (matrix)
    );

endmodule

// File: rtl/bms_scan_chk.sv
module bms_scan_chk #(
    parameter int LANES     = 8,
    parameter int MAX_BANKS = 8
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       scan_en,
    input logic                       tick,
    input logic                       scan_run,
    input logic [MAX_BANKS-1:0]       row_sel,
    input logic [MAX_BANKS*LANES-1:0] matrix,
    input logic                       scan_done
);

    assert_sel_onehot_R1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(row_sel));

    assert_sel_off_when_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !scan_en |=> (row_sel == '0));

    assert_no_step_without_tick_R3: assert property (@(posedge clk) disable iff (rst)
        (scan_run && scan_en && !tick) |=> $stable(row_sel));

    assert_done_clears_R7: assert property (@(posedge clk) disable iff (rst)
        !scan_en |=> !scan_done);

    assert_matrix_held_R8: assert property (@(posedge clk) disable iff (rst)
        !scan_en |=> $stable(matrix));

endmodule

bind bank_matrix_scan bms_scan_chk #(
    .LANES     (LANES),
    .MAX_BANKS (MAX_BANKS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .scan_en   (scan_en),
    .tick      (tick),
    .scan_run  (scan_run),
    .row_sel   (row_sel),
    .matrix    (matrix),
    .scan_done (scan_done)
);

// File: tb/sim_bank_matrix_scan.sv
module sim_bank_matrix_scan;

    localparam int LANES = 8;
    localparam int MAXB  = 8;
    localparam int NT    = 4;
    localparam int FT    = 2;
    localparam int RW    = $clog2(MAXB + 1);
    localparam int NV    = 6;

    // vector table: requested rows, fast mode, cycles until done
    localparam int V_REQ  [NV] = '{3, 8, 2, 0, 15, 5};
    localparam int V_FAST [NV] = '{0, 0, 1, 0, 1, 1};
    localparam int V_CYC  [NV] = '{13, 33, 5, 9, 17, 11};

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic                  scan_en = 1'b0;
    logic                  tick = 1'b0;
    logic                  fast_mode = 1'b0;
    logic [RW-1:0]         row_count = '0;
    logic [LANES-1:0]      in_bits;
    logic [MAXB-1:0]       row_sel;
    logic [MAXB*LANES-1:0] matrix;
    logic                  scan_done;

    logic [LANES-1:0] pat   [MAXB];
    logic [LANES-1:0] model [MAXB];

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    bank_matrix_scan #(
        .LANES      (LANES),
        .MAX_BANKS  (MAXB),
        .NORM_TICKS (NT),
        .FAST_TICKS (FT)
    ) u0 (
        .clk       (clk),
        .rst       (rst),
        .scan_en   (scan_en),
        .tick      (tick),
        .fast_mode (fast_mode),
        .row_count (row_count),
        .in_bits   (in_bits),
        .row_sel   (row_sel),
        .matrix    (matrix),
        .scan_done (scan_done)
    );

    // the grid: the selected row presents its pattern on the shared lines
    always_comb begin
        in_bits = '0;
        for (int b = 0; b < MAXB; b++)
            if (row_sel[b]) in_bits = pat[b];
    end

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_pat(input int seed);
        for (int b = 0; b < MAXB; b++) pat[b] = 8'(b * 37 + seed * 91 + 5);
    endtask

    function automatic logic [MAXB*LANES-1:0] model_flat();
        logic [MAXB*LANES-1:0] v;
        for (int b = 0; b < MAXB; b++) v[b*LANES +: LANES] = model[b];
        return v;
    endfunction

    function automatic int clampb(input int r);
        if (r < 2)    return 2;
        if (r > MAXB) return MAXB;
        return r;
    endfunction

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        int n;
        bit oh_ok;
        for (int b = 0; b < MAXB; b++) model[b] = '0;
        set_pat(0);
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        // R9: reset state
        check(matrix == '0, "R9 matrix", 64'(matrix), 64'd0);
        check(row_sel == '0, "R9 sel", 64'(row_sel), 64'd0);
        check(!scan_done, "R9 done", 64'(scan_done), 64'd0);
        tick = 1'b1;

        for (int v = 0; v < NV; v++) begin
            scan_en = 1'b0;
            @(negedge clk);
            @(negedge clk);
            check(row_sel == '0, "R2 sel idle", 64'(row_sel), 64'd0);
            check(!scan_done, "R7 done idle", 64'(scan_done), 64'd0);
            row_count = RW'(V_REQ[v]);
            fast_mode = V_FAST[v][0];
            set_pat(v + 1);
            scan_en = 1'b1;
            n = 0;
            oh_ok = 1'b1;
            while (n < 200 && !scan_done) begin
                @(posedge clk);
                n++;
                @(negedge clk);
                if (n == 1) check(row_sel == 8'h01, "R1 start row 0", 64'(row_sel), 64'h1);
                if ($countones(row_sel) != 1) oh_ok = 1'b0;
            end
            check(oh_ok, "R1 one-hot select", 64'(row_sel), 64'h1);
            // R3 R5 R6: done edge depends on dwell and clamped row count
            check(n == V_CYC[v], (v == 3 || v == 4) ? "R5 clamp timing" : "R6 R3 done timing",
                  64'(n), 64'(V_CYC[v]));
            for (int b = 0; b < clampb(V_REQ[v]); b++) model[b] = pat[b];
            check(matrix == model_flat(), "R4 R8 captured rows", matrix, model_flat());
        end

        // R8 R6: second pass refreshes rows 0..4, done stays high
        set_pat(9);
        repeat (5 * FT) @(posedge clk);
        @(negedge clk);
        for (int b = 0; b < 5; b++) model[b] = pat[b];
        check(matrix == model_flat(), "R8 second pass refresh", matrix, model_flat());
        check(scan_done, "R6 done held", 64'(scan_done), 64'd1);

        // R7: done clears after disable
        scan_en = 1'b0;
        @(negedge clk);
        check(!scan_done, "R7 done cleared", 64'(scan_done), 64'd0);

        // R3: no ticks, no progress
        tick = 1'b0;
        scan_en = 1'b1;
        repeat (20) @(negedge clk);
        check(row_sel == 8'h01, "R3 stalled on row 0", 64'(row_sel), 64'h1);
        check(!scan_done, "R3 no done without ticks", 64'(scan_done), 64'd0);

        // R8: disabled scan leaves matrix untouched despite new inputs
        scan_en = 1'b0;
        set_pat(13);
        @(negedge clk);
        check(row_sel == '0, "R2 sel off", 64'(row_sel), 64'd0);
        tick = 1'b1;
        repeat (10) @(negedge clk);
        check(matrix == model_flat(), "R8 hold while disabled", matrix, model_flat());

        // R2: restart from row 0 and complete a pass again
        scan_en = 1'b1;
        n = 0;
        while (n < 200 && !scan_done) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (n == 1) check(row_sel == 8'h01, "R2 restart row 0", 64'(row_sel), 64'h1);
        end
        check(n == 11, "R6 done after restart", 64'(n), 64'd11);
        for (int b = 0; b < 5; b++) model[b] = pat[b];
        check(matrix == model_flat(), "R4 rows after restart", matrix, model_flat());

        summary();
        $finish;
    end

endmodule